// File: doc/BRIEF.md
# Dual-Width Serial Data FIFO Port

This block sits between a 32-bit register bus and a pair of byte-wide FIFOs that feed and drain a serial shift engine. One FIFO carries bytes toward the shifter and the other collects bytes coming back from it. A single data port on the bus side serves both FIFOs: a bus write pushes into the transmit FIFO and a bus read pops from the receive FIFO.

A width-select input decides how much each bus access moves. In byte mode one access moves one byte. In word mode one access moves a packed little-endian word of up to four bytes. A programmable length counter tracks how many bytes the current word-mode transfer still owes. When fewer than four remain, the final word pushes only the bytes that are left.

The shift engine side is a plain pop/push pair with a level count for each FIFO. Bus writes that do not fit are dropped and flagged. Bus reads from an empty FIFO return zero. A clear input empties both FIFOs and zeroes the length. Contents buffered across a change of the width select are not defined.

Top module: `spi_fifo_port`

## Requirements
- R1: Each FIFO holds up to DEPTH (default 64) bytes. `tx_level` and `rx_level` report the byte count and never exceed DEPTH.
- R2: With `wide_en` low, an accepted bus write pushes `wr_data[7:0]` into the transmit FIFO as one byte. Bytes leave at `tx_data` in first-in first-out order, one per `tx_pop` pulse.
- R3: With `wide_en` low, a bus read of a non-empty receive FIFO pops one byte. `rd_data` shows it as `{24'h0, byte}` after the clock edge that takes the read.
- R4: With `wide_en` high and the remaining length zero or at least four, a bus write pushes four bytes. `wr_data[7:0]` goes first and `wr_data[31:24]` goes last.
- R5: With `wide_en` high, a bus read pops min(4, `rx_level`) bytes. The oldest byte lands in `rd_data[7:0]`, and lanes with no byte read as zero.
- R6: Writing `len_wr_valid` loads `remaining`. Each accepted word-mode write with `remaining` nonzero pushes min(4, `remaining`) bytes from the low lanes and lowers `remaining` by that amount. With `remaining` zero the word pushes four bytes and `remaining` stays zero. Byte-mode writes leave `remaining` unchanged.
- R7: A bus write whose byte count exceeds the free space in the transmit FIFO at that cycle is dropped whole. It sets the sticky `tx_ovf`, and `tx_level` and `remaining` stay unchanged.
- R8: A bus read from an empty receive FIFO returns zero and leaves `rx_level` at zero.
- R9: A `clr` pulse empties both FIFOs, sets `remaining` to zero and clears `tx_ovf`.
- R10: After reset, both levels are zero, `remaining` is zero, `tx_ovf` is low and `rd_data` is zero.
- R11: An `rx_push` while the receive FIFO is full is dropped, and the FIFO keeps its original DEPTH bytes in order. A `tx_pop` while the transmit FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Empties both FIFOs, zeroes length, clears overflow |
| wide_en | input | 1 | 0: byte access, 1: packed word access |
| wr_valid | input | 1 | Bus write to the data port |
| wr_data | input | 32 | Bus write data |
| rd_valid | input | 1 | Bus read from the data port |
| rd_data | output | 32 | Read data, registered on the edge that takes the read |
| len_wr_valid | input | 1 | Load the transfer length |
| len_wr_data | input | 16 | Transfer length in bytes |
| remaining | output | 16 | Bytes still owed in word mode |
| tx_ovf | output | 1 | Sticky dropped-write flag |
| tx_pop | input | 1 | Shift engine takes one transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_level | output | 7 | Transmit FIFO byte count |
| rx_push | input | 1 | Shift engine delivers one received byte |
| rx_data | input | 8 | Received byte |
| rx_level | output | 7 | Receive FIFO byte count |

## Verification
The hardest state to reach is a word write that overflows only partially. Here the transmit FIFO has some free space, but fewer bytes than the word would push. The stimulus fills the FIFO to 62 bytes with byte writes and then issues a four-byte word write. It checks that the write is dropped whole, that the level and length do not move, and that the original bytes still drain in order. A second case builds a receive FIFO of three bytes and reads it as a word, which exercises the zero-filled upper lane.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
   typedef enum logic {ACC_BYTE = 1'b0, ACC_WORD = 1'b1} acc_mode_e;
   localparam int BYTE_W = 8;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
   parameter int DEPTH = 64,
   parameter int LANES = 4,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1),
   localparam int NW = $clog2(LANES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic [NW-1:0]      push_n,
   input  logic [8*LANES-1:0] push_data,
   input  logic [NW-1:0]      pop_n,
   output logic [8*LANES-1:0] head,
   output logic [CW-1:0]      level
);
   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < LANES) begin : g_bad_depth
         $error("spi_byte_fifo: DEPTH must be a power of two no smaller than LANES");
      end
   endgenerate

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         if (NW'(i) < push_n) mem[wp + AW'(i)] <= push_data[8*i +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         wp  <= wp + AW'(push_n);
         rp  <= rp + AW'(pop_n);
         cnt <= cnt + CW'(push_n) - CW'(pop_n);
      end
   end

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_head
         assign head[8*g +: 8] = (CW'(g) < cnt) ? mem[rp + AW'(g)] : 8'h00;
      end
   endgenerate

   assign level = cnt;

   // R1: occupancy never passes capacity
   p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));
   // R7: the port never pushes more than the free space
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (push_n != '0) |-> (CW'(push_n) <= CW'(DEPTH) - level));
   // R8: the port never pops more than it holds
   p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (pop_n != '0) |-> (CW'(pop_n) <= level));
endmodule

// File: rtl/spi_len_track.sv
module spi_len_track #(
   parameter int LEN_W = 16,
   parameter int LANES = 4,
   localparam int NW = $clog2(LANES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             consume,
   output logic [NW-1:0]    take,
   output logic [LEN_W-1:0] remaining
);
   logic [LEN_W-1:0] rem;

   always_comb begin
      if (rem == '0 || rem >= LEN_W'(LANES)) take = NW'(LANES);
      else                                   take = rem[NW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr)            rem <= '0;
      else if (load)                rem <= load_val;
      else if (consume && rem != '0) rem <= rem - LEN_W'(take);
   end

   assign remaining = rem;

   // R6: without a load, the count can only fall
   p_rem_monotonic_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !clr) |=> (remaining <= $past(remaining)));
endmodule

// File: rtl/spi_fifo_port.sv
module spi_fifo_port
   import spi_fifo_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int BUS_W = 32,
   parameter int LEN_W = 16,
   localparam int LANES = BUS_W / BYTE_W,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int NW = $clog2(LANES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wide_en,
   input  logic             wr_valid,
   input  logic [BUS_W-1:0] wr_data,
   input  logic             rd_valid,
   output logic [BUS_W-1:0] rd_data,
   input  logic             len_wr_valid,
   input  logic [LEN_W-1:0] len_wr_data,
   output logic [LEN_W-1:0] remaining,
   output logic             tx_ovf,
   input  logic             tx_pop,
   output logic [7:0]       tx_data,
   output logic [CW-1:0]    tx_level,
   input  logic             rx_push,
   input  logic [7:0]       rx_data,
   output logic [CW-1:0]    rx_level
);
   generate
      if (BUS_W % BYTE_W != 0 || LANES < 2) begin : g_bad_bus
         $error("spi_fifo_port: BUS_W must be a multiple of 8 and at least 16");
      end
   endgenerate

   acc_mode_e mode;
   assign mode = acc_mode_e'(wide_en);

   logic [NW-1:0]    take, tx_want, tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
   logic [BUS_W-1:0] tx_head, rx_head, rd_next;
   logic             tx_fits, consume;

   assign tx_want   = (mode == ACC_WORD) ? take : NW'(1);
   assign tx_fits   = CW'(tx_want) <= (CW'(DEPTH) - tx_level);
   assign tx_push_n = (wr_valid && tx_fits) ? tx_want : '0;
   assign tx_pop_n  = (tx_pop && tx_level != '0) ? NW'(1) : '0;
   assign consume   = wr_valid && tx_fits && (mode == ACC_WORD);

   spi_len_track #(.LEN_W(LEN_W), .LANES(LANES)) u_len (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .load(len_wr_valid), .load_val(len_wr_data),
      .consume(consume), .take(take), .remaining(remaining));

   spi_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .push_n(tx_push_n), .push_data(wr_data),
      .pop_n(tx_pop_n), .head(tx_head), .level(tx_level));

   assign tx_data = tx_head[7:0];

   always_ff @(posedge clk) begin
      if (!rst_n || clr)           tx_ovf <= 1'b0;
      else if (wr_valid && !tx_fits) tx_ovf <= 1'b1;
   end

   assign rx_push_n = (rx_push && rx_level != CW'(DEPTH)) ? NW'(1) : '0;
   always_comb begin
      if (mode == ACC_WORD)
         rx_pop_n = (rx_level >= CW'(LANES)) ? NW'(LANES) : rx_level[NW-1:0];
      else
         rx_pop_n = (rx_level != '0) ? NW'(1) : '0;
      if (!rd_valid) rx_pop_n = '0;
   end

   spi_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .push_n(rx_push_n), .push_data({{(BUS_W-8){1'b0}}, rx_data}),
      .pop_n(rx_pop_n), .head(rx_head), .level(rx_level));

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
         if (g == 0) begin : g_low
            assign rd_next[7:0] = rx_head[7:0];
         end else begin : g_up
            assign rd_next[8*g +: 8] = (mode == ACC_WORD) ? rx_head[8*g +: 8] : 8'h00;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        rd_data <= '0;
      else if (rd_valid) rd_data <= rd_next;
   end

   // R7: the flag holds until clear
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf && !clr) |=> tx_ovf);
   // R7: a rejected write leaves the level alone
   p_drop_keeps_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !tx_fits && !tx_pop && !clr) |=> (tx_level == $past(tx_level)));
   // R9: clear empties everything
   p_clr_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (tx_level == '0 && rx_level == '0 && remaining == '0 && !tx_ovf));
   // R8: empty read returns zero
   p_empty_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rx_level == '0) |=> (rd_data == '0));
   // R3: byte reads never carry upper lanes
   p_byte_read_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !wide_en) |=> (rd_data[BUS_W-1:8] == '0));
endmodule

// File: tb/tb_spi_fifo_port.sv
module tb_spi_fifo_port;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n, clr, wide_en, wr_valid, rd_valid, len_wr_valid, tx_pop, rx_push, tx_ovf;
   logic [31:0] wr_data, rd_data;
   logic [15:0] len_wr_data, remaining;
   logic [7:0]  tx_data, rx_data;
   logic [6:0]  tx_level, rx_level;

   spi_fifo_port dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wide_en(wide_en),
      .wr_valid(wr_valid), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
      .len_wr_valid(len_wr_valid), .len_wr_data(len_wr_data), .remaining(remaining),
      .tx_ovf(tx_ovf), .tx_pop(tx_pop), .tx_data(tx_data), .tx_level(tx_level),
      .rx_push(rx_push), .rx_data(rx_data), .rx_level(rx_level));

   int tests = 0, fails = 0;

   // {wide, length, data, expected byte count}
   localparam logic [51:0] VEC [6] = '{
      {1'b0, 16'd0, 32'hA5A5_A53C, 3'd1},
      {1'b1, 16'd0, 32'h4433_2211, 3'd4},
      {1'b1, 16'd1, 32'hDEAD_BEEF, 3'd1},
      {1'b1, 16'd2, 32'h0BAD_F00D, 3'd2},
      {1'b1, 16'd3, 32'hCAFE_1234, 3'd3},
      {1'b1, 16'd9, 32'h8765_4321, 3'd4}
   };

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input bit w, input logic [31:0] d);
      @(negedge clk); wide_en = w; wr_valid = 1'b1; wr_data = d;
      @(negedge clk); wr_valid = 1'b0;
   endtask

   task automatic bus_rd(input bit w);
      @(negedge clk); wide_en = w; rd_valid = 1'b1;
      @(negedge clk); rd_valid = 1'b0;
   endtask

   task automatic load_len(input logic [15:0] v);
      @(negedge clk); len_wr_valid = 1'b1; len_wr_data = v;
      @(negedge clk); len_wr_valid = 1'b0;
   endtask

   task automatic do_clr();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic pop_tx(output logic [7:0] b);
      @(negedge clk); b = tx_data; tx_pop = 1'b1;
      @(negedge clk); tx_pop = 1'b0;
   endtask

   task automatic push_rx(input logic [7:0] b);
      @(negedge clk); rx_push = 1'b1; rx_data = b;
      @(negedge clk); rx_push = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [7:0] b;
      rst_n = 1'b0; clr = 0; wide_en = 0; wr_valid = 0; rd_valid = 0; len_wr_valid = 0;
      tx_pop = 0; rx_push = 0; wr_data = '0; len_wr_data = '0; rx_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(tx_level == 0 && rx_level == 0, "R10 levels", {tx_level, rx_level}, 0);
      chk(remaining == 0 && !tx_ovf && rd_data == 0, "R10 length/flag/data",
          {remaining, tx_ovf, rd_data}, 0);

      // table walk: R2 R4 R6
      for (int v = 0; v < 6; v++) begin
         logic        w;
         logic [15:0] ln, exp_rem;
         logic [31:0] d;
         logic [2:0]  n;
         {w, ln, d, n} = VEC[v];
         do_clr();
         load_len(ln);
         bus_wr(w, d);
         exp_rem = (!w || ln == 0) ? ln : (ln > 4 ? ln - 16'd4 : 16'd0);
         chk(tx_level == 7'(n), "R6 pushed count (R4)", tx_level, n);
         chk(remaining == exp_rem, "R6 remaining", remaining, exp_rem);
         for (int k = 0; k < int'(n); k++) begin
            pop_tx(b);
            chk(b == d[8*k +: 8], "R2 R4 byte order", b, d[8*k +: 8]);
         end
      end

      // R6: length 5 across words, then zero-length word
      do_clr();
      load_len(16'd5);
      bus_wr(1'b1, 32'h0403_0201);
      bus_wr(1'b1, 32'hFFFF_FF05);
      chk(tx_level == 5 && remaining == 0, "R6 tail word", {tx_level, remaining}, {7'd5, 16'd0});
      bus_wr(1'b1, 32'h0908_0706);
      chk(tx_level == 9 && remaining == 0, "R6 zero length full word", {tx_level, remaining}, {7'd9, 16'd0});
      for (int k = 1; k <= 9; k++) begin
         pop_tx(b);
         chk(b == 8'(k), "R6 stream order", b, k);
      end
      // R11 pop on empty
      pop_tx(b);
      chk(tx_level == 0, "R11 tx pop when empty", tx_level, 0);

      // R1 R7: fill to 62, partial-fit word dropped, then fill to 64 and overflow byte
      do_clr();
      load_len(16'd40);
      for (int k = 0; k < 62; k++) bus_wr(1'b0, 32'(k));
      chk(!tx_ovf, "R7 no flag before overflow", tx_ovf, 0);
      bus_wr(1'b1, 32'hEEEE_EEEE);
      chk(tx_level == 62 && tx_ovf, "R7 partial-fit word dropped", {tx_level, tx_ovf}, {7'd62, 1'b1});
      chk(remaining == 40, "R7 length untouched by drop", remaining, 40);
      bus_wr(1'b0, 32'd62); bus_wr(1'b0, 32'd63);
      chk(tx_level == 64, "R1 full at depth", tx_level, 64);
      bus_wr(1'b0, 32'h77);
      chk(tx_level == 64 && tx_ovf, "R7 byte dropped when full", {tx_level, tx_ovf}, {7'd64, 1'b1});
      for (int k = 0; k < 64; k++) begin
         pop_tx(b);
         chk(b == 8'(k), "R1 R7 contents intact", b, k);
      end
      chk(tx_ovf, "R7 flag sticky", tx_ovf, 1);

      // R3 byte reads, R8 empty read
      do_clr();
      chk(!tx_ovf, "R9 clear drops flag", tx_ovf, 0);
      push_rx(8'h5A); push_rx(8'hC3);
      bus_rd(1'b0);
      chk(rd_data == 32'h5A && rx_level == 1, "R3 byte read", rd_data, 32'h5A);
      bus_rd(1'b0);
      chk(rd_data == 32'hC3, "R3 second byte", rd_data, 32'hC3);
      bus_rd(1'b0);
      chk(rd_data == 0 && rx_level == 0, "R8 empty read", rd_data, 0);

      // R5 word read, full and partial
      for (int k = 0; k < 7; k++) push_rx(8'h10 + 8'(k));
      bus_rd(1'b1);
      chk(rd_data == 32'h1312_1110 && rx_level == 3, "R5 full word read", rd_data, 32'h1312_1110);
      bus_rd(1'b1);
      chk(rd_data == 32'h0016_1514 && rx_level == 0, "R5 partial word zero fill", rd_data, 32'h0016_1514);
      bus_rd(1'b1);
      chk(rd_data == 0, "R8 empty word read", rd_data, 0);

      // R11 rx push when full
      for (int k = 0; k < 65; k++) push_rx(8'(k));
      chk(rx_level == 64, "R11 rx full drop", rx_level, 64);
      for (int k = 0; k < 16; k++) begin
         bus_rd(1'b1);
         chk(rd_data == {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)}, "R11 rx order kept",
             rd_data, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
      end

      // R9 clear
      push_rx(8'h01); bus_wr(1'b0, 32'h02); load_len(16'd77);
      do_clr();
      chk(tx_level == 0 && rx_level == 0 && remaining == 0, "R9 clear", {tx_level, rx_level, remaining}, 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule